// File: doc/BRIEF.md
# Move Instruction Decoder with Destination Prefix

This block decodes fixed 16-bit instruction words for a core in which every operation is a transfer from a source to a destination register. Each word is split into a source operand and a destination operand. The source is either an 8-bit immediate or a module/index register address. The destination is a module specifier plus a register number within that module. Register file access, side effects and fetch are handled elsewhere.

A short destination field reaches only the low eight registers of a module. To reach the upper registers, software first writes the prefix register. That write is absorbed by the decoder and issues no transfer. The prefix then supplies the two high destination bits of the next issued instruction and clears itself afterwards. As a result, a prefixed transfer costs one extra issue slot.

Words enter on a valid/ready handshake, and decoded operands leave on a second valid/ready handshake through a one-entry register stage. A word is accepted on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While the output is valid and `out_ready` is low, the output fields stay frozen and no new word is taken.

Top module: `move_decoder`

## Requirements
- R1: A word with bit 15 = 0 has an immediate source: the issued output has `src_is_imm` = 1, `imm_val` = bits 7:0, and `src_mod` and `src_idx` both zero.
- R2: A word with bit 15 = 1 has a register source: the issued output has `src_is_imm` = 0, `src_mod` = bits 3:0, `src_idx` = bits 7:4, and `imm_val` zero.
- R3: For every issued word, `dst_mod` = bits 11:8 and `dst_reg[2:0]` = bits 14:12.
- R4: When no prefix is pending, `dst_reg[4:3]` of the issued word is zero.
- R5: A word with bit 15 = 0 and bits 14:8 = 7'h0B (module 11, subindex 0) is a prefix write. It issues nothing: `out_valid` is low in the following cycle. It loads the prefix from bits 1:0. A later prefix write overwrites an earlier one.
- R6: The next accepted word that is not a prefix write takes `dst_reg[4:3]` from the prefix. The prefix returns to zero after that word.
- R7: A word with bit 15 = 1 and bits 14:8 = 7'h0B is an ordinary transfer to module 11, register 0 (plus any pending prefix). It does not load the prefix.
- R8: An accepted non-prefix word appears with `out_valid` high one clock after acceptance. Back-to-back words sustain one word per clock.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output field holds its value.
- R10: A synchronous reset clears `out_valid`, all output fields and the pending prefix. `in_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Decoder can accept a word |
| instr | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded transfer valid |
| out_ready | input | 1 | Consumer takes the decoded transfer |
| src_is_imm | output | 1 | Source is the immediate |
| src_mod | output | 4 | Source module specifier |
| src_idx | output | 4 | Source register index |
| imm_val | output | 8 | Immediate value |
| dst_mod | output | 4 | Destination module specifier |
| dst_reg | output | 5 | Destination register, prefix bits on top |

## Verification
Every decoded field is due exactly one clock after the edge that accepts its word. The bench therefore drives a word at a falling edge and checks that word's outputs at the next falling edge, before it drives the following word. A prefix write is likewise judged one clock later by `out_valid` being low, and its effect is checked on the next word, in the same cycle that word's fields are checked. A reference prefix value is kept in the bench and updated only after each check. Under back-pressure, the held outputs and the low `in_ready` are sampled on each stalled cycle, and the word that was waiting is checked one clock after `out_ready` returns.

// File: rtl/mvdec_pkg.sv
package mvdec_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned MOD_W   = 4;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned SUB_W   = 3;
  localparam int unsigned IMM_W   = 8;
  localparam int unsigned DADDR_W = MOD_W + SUB_W;
  localparam int unsigned FMT_BIT = WORD_W - 1;

  typedef struct packed {
    logic             imm_fmt;
    logic [MOD_W-1:0] src_mod;
    logic [IDX_W-1:0] src_idx;
    logic [IMM_W-1:0] imm;
    logic [MOD_W-1:0] dst_mod;
    logic [SUB_W-1:0] dst_sub;
    logic             is_pfx;
  } fields_t;
endpackage

// File: rtl/mvdec_fields.sv
module mvdec_fields
  import mvdec_pkg::*;
#(
  parameter logic [DADDR_W-1:0] PFX_DST = 7'h0B
) (
  input  logic [WORD_W-1:0] instr,
  output fields_t           f
);
  logic fmt;
  logic [DADDR_W-1:0] daddr;

  always_comb begin
    fmt      = ~instr[FMT_BIT];
    daddr    = instr[FMT_BIT-1 -: DADDR_W];
    f.imm_fmt = fmt;
    f.src_mod = fmt ? '0 : instr[MOD_W-1:0];
    f.src_idx = fmt ? '0 : instr[IMM_W-1 -: IDX_W];
    f.imm     = fmt ? instr[IMM_W-1:0] : '0;
    f.dst_mod = daddr[MOD_W-1:0];
    f.dst_sub = daddr[DADDR_W-1 -: SUB_W];
    f.is_pfx  = fmt && (daddr == PFX_DST);
  end
endmodule

// File: rtl/mvdec_prefix.sv
module mvdec_prefix #(
  parameter int unsigned PFX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             is_pfx,
  input  logic [PFX_W-1:0] load_val,
  output logic [PFX_W-1:0] pfx
);
  // A prefix write loads; any other accepted word consumes and clears it.
  always_ff @(posedge clk) begin
    if (rst) begin
      pfx <= '0;
    end else if (accept) begin
      pfx <= is_pfx ? load_val : '0;
    end
  end
endmodule

// File: rtl/mvdec_slice.sv
module mvdec_slice
  import mvdec_pkg::*;
#(
  parameter int unsigned DREG_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  fields_t           f,
  input  logic [DREG_W-1:0] dreg_in,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              src_is_imm,
  output logic [MOD_W-1:0]  src_mod,
  output logic [IDX_W-1:0]  src_idx,
  output logic [IMM_W-1:0]  imm_val,
  output logic [MOD_W-1:0]  dst_mod,
  output logic [DREG_W-1:0] dst_reg
);
  logic issue;

  assign in_ready = ~out_valid | out_ready;
  assign issue    = accept & ~f.is_pfx;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      src_is_imm <= 1'b0;
      src_mod    <= '0;
      src_idx    <= '0;
      imm_val    <= '0;
      dst_mod    <= '0;
      dst_reg    <= '0;
    end else if (in_ready) begin
      out_valid <= issue;
      if (issue) begin
        src_is_imm <= f.imm_fmt;
        src_mod    <= f.src_mod;
        src_idx    <= f.src_idx;
        imm_val    <= f.imm;
        dst_mod    <= f.dst_mod;
        dst_reg    <= dreg_in;
      end
    end
  end
endmodule

// File: rtl/move_decoder.sv
module move_decoder
  import mvdec_pkg::*;
#(
  parameter int unsigned        PFX_W   = 2,
  parameter logic [DADDR_W-1:0] PFX_DST = 7'h0B,
  localparam int unsigned       DREG_W  = SUB_W + PFX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] instr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              src_is_imm,
  output logic [MOD_W-1:0]  src_mod,
  output logic [IDX_W-1:0]  src_idx,
  output logic [IMM_W-1:0]  imm_val,
  output logic [MOD_W-1:0]  dst_mod,
  output logic [DREG_W-1:0] dst_reg
);
  fields_t           f;
  logic [PFX_W-1:0]  pfx;
  logic              accept;
  logic [DREG_W-1:0] dreg_in;

  assign accept  = in_valid & in_ready;
  assign dreg_in = {pfx, f.dst_sub};

  mvdec_fields #(.PFX_DST(PFX_DST)) u_fields (
    .instr (instr),
    .f     (f)
  );

  mvdec_prefix #(.PFX_W(PFX_W)) u_prefix (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .is_pfx   (f.is_pfx),
    .load_val (f.imm[PFX_W-1:0]),
    .pfx      (pfx)
  );

  mvdec_slice #(.DREG_W(DREG_W)) u_slice (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .f          (f),
    .dreg_in    (dreg_in),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .src_is_imm (src_is_imm),
    .src_mod    (src_mod),
    .src_idx    (src_idx),
    .imm_val    (imm_val),
    .dst_mod    (dst_mod),
    .dst_reg    (dst_reg)
  );
endmodule

// File: rtl/move_decoder_chk.sv
module move_decoder_chk #(
  parameter int unsigned DREG_W  = 5,
  parameter logic [6:0]  PFX_DST = 7'h0B
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [15:0]       instr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              src_is_imm,
  input logic [3:0]        src_mod,
  input logic [3:0]        src_idx,
  input logic [7:0]        imm_val,
  input logic [3:0]        dst_mod,
  input logic [DREG_W-1:0] dst_reg
);
  logic take_pfx, take_xfer;
  assign take_pfx  = in_valid && in_ready && !instr[15] && (instr[14:8] == PFX_DST);
  assign take_xfer = in_valid && in_ready && !take_pfx;

  assert_reset_clears_R10: assert property (@(posedge clk) rst |=> !out_valid);

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(src_is_imm) && $stable(src_mod)
      && $stable(src_idx) && $stable(imm_val) && $stable(dst_mod) && $stable(dst_reg)));

  assert_prefix_silent_R5: assert property (@(posedge clk) disable iff (rst)
    take_pfx |=> !out_valid);

  assert_issue_next_R8: assert property (@(posedge clk) disable iff (rst)
    take_xfer |=> (out_valid && dst_mod == $past(instr[11:8])));

  assert_imm_clean_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && src_is_imm) |-> (src_mod == 4'd0 && src_idx == 4'd0));

  assert_reg_clean_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !src_is_imm) |-> (imm_val == 8'd0));
endmodule

bind move_decoder move_decoder_chk #(.DREG_W(DREG_W), .PFX_DST(PFX_DST)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .instr      (instr),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .src_is_imm (src_is_imm),
  .src_mod    (src_mod),
  .src_idx    (src_idx),
  .imm_val    (imm_val),
  .dst_mod    (dst_mod),
  .dst_reg    (dst_reg)
);

// File: tb/move_decoder_test.sv
module move_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] instr = 16'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        src_is_imm;
  logic [3:0]  src_mod, src_idx, dst_mod;
  logic [7:0]  imm_val;
  logic [4:0]  dst_reg;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [1:0] mpfx = 2'b0;

  always #5 clk = ~clk;

  move_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .instr(instr),
    .out_valid(out_valid), .out_ready(out_ready), .src_is_imm(src_is_imm),
    .src_mod(src_mod), .src_idx(src_idx), .imm_val(imm_val), .dst_mod(dst_mod),
    .dst_reg(dst_reg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic is_pfx_word(input logic [15:0] w);
    return !w[15] && (w[14:8] == 7'h0B);
  endfunction

  task automatic expect_word(input logic [15:0] w, input logic [1:0] p);
    if (is_pfx_word(w)) begin
      chk("R5 no issue", out_valid, 0);
    end else begin
      chk("R8 issued", out_valid, 1);
      if (!w[15]) begin
        chk("R1 flag", src_is_imm, 1);
        chk("R1 src zero", {src_mod, src_idx}, 0);
        chk("R1 imm", imm_val, w[7:0]);
      end else begin
        chk("R2 flag", src_is_imm, 0);
        chk("R2 src", {src_mod, src_idx}, {w[3:0], w[7:4]});
        chk("R2 imm zero", imm_val, 0);
      end
      chk("R3 dst", {dst_mod, dst_reg[2:0]}, {w[11:8], w[14:12]});
      if (p == 2'b0) chk("R4 upper", dst_reg[4:3], 0);
      else           chk("R6 upper", dst_reg[4:3], p);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic send_word(input logic [15:0] w);
    logic [1:0] p;
    p = mpfx;
    instr = w;
    in_valid = 1'b1;
    @(negedge clk);
    expect_word(w, p);
    mpfx = is_pfx_word(w) ? w[1:0] : 2'b0;
  endtask

  task automatic idle_check(input string req);
    in_valid = 1'b0;
    @(negedge clk);
    chk(req, out_valid, 0);
  endtask

  initial begin
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 out_valid", out_valid, 0);
    chk("R10 in_ready", in_ready, 1);
    chk("R10 fields", {src_is_imm, src_mod, src_idx, imm_val, dst_mod, dst_reg}, 0);

    // R5/R6: every prefix value against every destination address
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 128; d++) begin
        if (d != 7'h0B) begin
          send_word(16'h0B00 | 16'(p));
          send_word({1'b0 ^ d[0], 7'(d), 8'(d * 37 + p)});
        end
      end
    end

    // R5: second prefix overwrites first
    send_word(16'h0B01);
    send_word(16'h0B03);
    send_word(16'h2512);

    // R7: register-format write to the prefix address is a normal transfer
    send_word(16'h0B02);
    send_word(16'h8B34);
    chk("R7 issued", out_valid, 1);
    chk("R7 dst", {dst_mod, dst_reg}, {4'hB, 5'b10000});
    send_word(16'h8B34);
    chk("R7 no load", dst_reg, 5'b00000);

    // near-exhaustive sweep of all words in a scrambled order, back to back
    for (int i = 0; i < 65536; i++) send_word(16'(i * 40503 + 16'h1357));
    idle_check("R8 drains");

    // R9 back-pressure
    mpfx = 2'b0;
    send_word(16'h3C5A);
    out_ready = 1'b0;
    instr = 16'hF2A7;
    in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 in_ready low", in_ready, 0);
      chk("R9 hold", {out_valid, src_is_imm, imm_val, dst_mod, dst_reg}, {1'b1, 1'b1, 8'h5A, 4'hC, 5'd3});
    end
    out_ready = 1'b1;
    @(negedge clk);
    expect_word(16'hF2A7, 2'b0);
    idle_check("R9 drained");

    // R10 reset clears a pending prefix
    send_word(16'h0B03);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 valid after reset", out_valid, 0);
    mpfx = 2'b0;
    send_word(16'h5400);
    chk("R10 prefix cleared", dst_reg, 5'd5);
    idle_check("R10 idle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule